// File: doc/BRIEF.md
# Dual-Clock Line FIFO with Width Matching

This block buffers a stream of 18-bit words between two unrelated clock domains, for example one video line between a capture front end and a processing stage. Each side has its own free-running clock, active-low enable and active-low reset strobe. Each side also has its own width setting: full 18-bit words or 9-bit halves. A narrow writer has its halves packed into whole words. A narrow reader gets each stored word back as two halves.

A byte-order input selects which half comes first. It applies to packing, to unpacking, and to the half order on a full-width output bus. An active-low output enable decides what a read does. While it is low, the read loads the output register and drives the bus. While it is high, the bus floats and the word is consumed without being presented, which skips it. A retransmit strobe rewinds the read side to address zero so that a buffered line can be replayed.

Pointers cross between the domains as Gray codes through a chain of synchronizer flops. Full is computed on the write side and empty on the read side. Width selects and the byte-order input are static settings and change only while both resets are held.

Top module: `lbf_fifo`

## Requirements
- R1: While held in reset and right after release, `empty` is 1, `full` is 0 and the output register, seen on `dout` with `oe_n` low, is all zeros.
- R2: With both widths wide and little byte order, words leave in the order they entered. A word written on a write edge clears `empty` after the second following read edge when both clocks are the same. A read loads the output register on the read edge, so the word is on `dout` after that edge.
- R3: `full` is 1 exactly when DEPTH words are held. A write with `wen_n` low while `full` is 1 stores nothing and does not move the write pointer.
- R4: A read with `ren_n` low while `empty` is 1 changes neither the read pointer nor `dout`.
- R5: With `in_narrow`=1, input bits [8:0] carry a half. Two accepted writes make one stored word. In little order the first half lands in bits [8:0], and in big order it lands in bits [17:9].
- R6: With `out_narrow`=1, each read returns one half on `dout[8:0]` with `dout[17:9]`=0. The word's bits [8:0] come first in little order and bits [17:9] come first in big order. The read pointer advances after the second half.
- R7: With both widths wide and `big_end`=1, `dout` carries the stored bits [8:0] in [17:9] and the stored bits [17:9] in [8:0].
- R8: While `oe_n` is 1 the bus is released to high impedance. A read made then consumes its word or half but leaves the output register unchanged, so the skipped data never appears on `dout`.
- R9: `rt_n` low on a read edge sets the read pointer to 0 and the narrow-output phase to the first half. It takes priority over a read requested on the same edge, and the stored data can then be read again in order.
- R10: A reset strobe clears its side's pointer. The write reset also discards a half held by the packer, so the next narrow write starts a new word.
- R11: When `full` is 1, reads free space. `full` falls after the crossing delay, and writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Write-side reset strobe, active low |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data; bits [8:0] only in narrow mode |
| in_narrow | input | 1 | 1 selects 9-bit input halves |
| full | output | 1 | No free word, write domain |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Read-side reset strobe, active low |
| ren_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low; high floats the bus and skips reads |
| rt_n | input | 1 | Retransmit strobe, active low |
| out_narrow | input | 1 | 1 selects 9-bit output halves |
| big_end | input | 1 | 1 selects high-half-first order |
| empty | output | 1 | No stored word, read domain |
| dout | output | DW | Read data bus, tri-state |

## Verification
The bench builds the block with DEPTH=16, the default 18-bit word and two synchronizer stages. The short depth lets a few dozen writes reach `full`, pile up extra ignored writes, and drain back through the crossing. It also lets a buffered line be rewound with retransmit before any pointer wraps. Both clocks come from one source, which makes the two-edge crossing delay an exact cycle count. A behavioural queue model can then predict `empty`, `full` and `dout` on every cycle for every width and byte-order combination.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
   // Phase of the half-word packer and unpacker.
   typedef enum logic {
      SLOT_FIRST  = 1'b0,
      SLOT_SECOND = 1'b1
   } slot_e;

   // Which half of a word is handled first.
   typedef enum logic {
      ORDER_LITTLE = 1'b0,
      ORDER_BIG    = 1'b1
   } order_e;

   function automatic slot_e slot_flip(input slot_e s);
      return (s == SLOT_FIRST) ? SLOT_SECOND : SLOT_FIRST;
   endfunction
endpackage

// File: rtl/lbf_gray_sync.sv
module lbf_gray_sync #(
   parameter int W      = 11,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] gray_out,
   output logic [W-1:0] bin_out
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= gray_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign gray_out = stage_q[STAGES-1];

   // Gray to binary: each bit folds in all higher Gray bits.
   always_comb begin
      bin_out[W-1] = gray_out[W-1];
      for (int i = W-2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ gray_out[i];
   end
endmodule

// File: rtl/lbf_ram.sv
module lbf_ram #(
   parameter  int DW    = 18,
   parameter  int DEPTH = 1024,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] cell_q [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cell_q[waddr] <= wdata;
   end

   assign rdata = cell_q[raddr];
endmodule

// File: rtl/lbf_wr_ctrl.sv
module lbf_wr_ctrl
   import lbf_pkg::*;
#(
   parameter  int DW     = 18,
   parameter  int DEPTH  = 1024,
   parameter  int STAGES = 2,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = AW + 1,
   localparam int HW     = DW / 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wen_n,
   input  logic [DW-1:0] din,
   input  logic          in_narrow,
   input  logic          big_end,
   input  logic [PW-1:0] rgray_x,
   output logic          full,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [DW-1:0] wdata,
   output logic [PW-1:0] wgray,
   output logic [PW-1:0] wptr
);
   logic [PW-1:0] wbin_q, wbin_nx, wgray_q;
   logic [PW-1:0] rgray_s, rbin_s;
   logic [HW-1:0] hold_q;
   slot_e         slot_q;
   order_e        ord;
   logic          accept;

   lbf_gray_sync #(.W(PW), .STAGES(STAGES)) u_rsync (
      .clk      (wclk),
      .rst_n    (wrst_n),
      .gray_in  (rgray_x),
      .gray_out (rgray_s),
      .bin_out  (rbin_s)
   );

   assign ord    = big_end ? ORDER_BIG : ORDER_LITTLE;
   assign full   = (wbin_q - rbin_s) == PW'(DEPTH);
   assign accept = !wen_n && !full;
   assign we     = accept && (!in_narrow || slot_q == SLOT_SECOND);

   always_comb begin
      if (!in_narrow)
         wdata = din;
      else if (ord == ORDER_BIG)
         wdata = {hold_q, din[HW-1:0]};
      else
         wdata = {din[HW-1:0], hold_q};
   end

   assign wbin_nx = wbin_q + PW'(we);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
         hold_q  <= '0;
         slot_q  <= SLOT_FIRST;
      end else begin
         wbin_q  <= wbin_nx;
         wgray_q <= wbin_nx ^ (wbin_nx >> 1);
         if (accept && in_narrow) begin
            slot_q <= slot_flip(slot_q);
            if (slot_q == SLOT_FIRST) hold_q <= din[HW-1:0];
         end
      end
   end

   assign waddr = wbin_q[AW-1:0];
   assign wgray = wgray_q;
   assign wptr  = wbin_q;
endmodule

// File: rtl/lbf_rd_ctrl.sv
module lbf_rd_ctrl
   import lbf_pkg::*;
#(
   parameter  int DW     = 18,
   parameter  int DEPTH  = 1024,
   parameter  int STAGES = 2,
   localparam int AW     = $clog2(DEPTH),
   localparam int PW     = AW + 1,
   localparam int HW     = DW / 2
) (
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          ren_n,
   input  logic          oe_n,
   input  logic          rt_n,
   input  logic          out_narrow,
   input  logic          big_end,
   input  logic [PW-1:0] wgray_x,
   input  logic [DW-1:0] rdata,
   output logic          empty,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic [PW-1:0] rptr,
   output logic [DW-1:0] rd_q
);
   logic [PW-1:0] rbin_q, rbin_nx, rgray_q;
   logic [PW-1:0] wgray_s, wbin_s;
   logic [DW-1:0] q_q, out_val;
   logic [HW-1:0] lo, hi, first_h, second_h;
   slot_e         slot_q;
   order_e        ord;
   logic          take, adv, rewind;

   lbf_gray_sync #(.W(PW), .STAGES(STAGES)) u_wsync (
      .clk      (rclk),
      .rst_n    (rrst_n),
      .gray_in  (wgray_x),
      .gray_out (wgray_s),
      .bin_out  (wbin_s)
   );

   assign ord    = big_end ? ORDER_BIG : ORDER_LITTLE;
   assign empty  = (rbin_q == wbin_s);
   assign rewind = !rt_n;
   assign take   = !ren_n && !empty && !rewind;
   assign adv    = take && (!out_narrow || slot_q == SLOT_SECOND);

   assign lo       = rdata[HW-1:0];
   assign hi       = rdata[DW-1:HW];
   assign first_h  = (ord == ORDER_BIG) ? hi : lo;
   assign second_h = (ord == ORDER_BIG) ? lo : hi;

   always_comb begin
      if (out_narrow)
         out_val = {{(DW-HW){1'b0}}, (slot_q == SLOT_SECOND) ? second_h : first_h};
      else if (ord == ORDER_BIG)
         out_val = {lo, hi};
      else
         out_val = rdata;
   end

   always_comb begin
      if (rewind)   rbin_nx = '0;
      else          rbin_nx = rbin_q + PW'(adv);
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
         slot_q  <= SLOT_FIRST;
         q_q     <= '0;
      end else begin
         rbin_q  <= rbin_nx;
         rgray_q <= rbin_nx ^ (rbin_nx >> 1);
         if (rewind)
            slot_q <= SLOT_FIRST;
         else if (take && out_narrow)
            slot_q <= slot_flip(slot_q);
         if (take && !oe_n) q_q <= out_val;
      end
   end

   assign raddr = rbin_q[AW-1:0];
   assign rgray = rgray_q;
   assign rptr  = rbin_q;
   assign rd_q  = q_q;
endmodule

// File: rtl/lbf_fifo.sv
module lbf_fifo #(
   parameter  int DW          = 18,
   parameter  int DEPTH       = 1024,
   parameter  int SYNC_STAGES = 2,
   localparam int AW          = $clog2(DEPTH),
   localparam int PW          = AW + 1
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wen_n,
   input  logic [DW-1:0] din,
   input  logic          in_narrow,
   output logic          full,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          ren_n,
   input  logic          oe_n,
   input  logic          rt_n,
   input  logic          out_narrow,
   input  logic          big_end,
   output logic          empty,
   output wire  [DW-1:0] dout
);
   if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("lbf_fifo: DEPTH must be a power of two of at least 2");
   end
   if ((DW < 2) || (DW % 2 != 0)) begin : g_bad_width
      $error("lbf_fifo: DW must be even and at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lbf_fifo: SYNC_STAGES must be at least 2");
   end

   logic          we;
   logic [AW-1:0] waddr, raddr;
   logic [DW-1:0] wdata, rdata, rd_q;
   logic [PW-1:0] wgray, rgray, wptr, rptr;

   lbf_wr_ctrl #(.DW(DW), .DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_wr (
      .wclk      (wclk),
      .wrst_n    (wrst_n),
      .wen_n     (wen_n),
      .din       (din),
      .in_narrow (in_narrow),
      .big_end   (big_end),
      .rgray_x   (rgray),
      .full      (full),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .wgray     (wgray),
      .wptr      (wptr)
   );

   lbf_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .wclk  (wclk),
      .we    (we),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (rdata)
   );

   lbf_rd_ctrl #(.DW(DW), .DEPTH(DEPTH), .STAGES(SYNC_STAGES)) u_rd (
      .rclk       (rclk),
      .rrst_n     (rrst_n),
      .ren_n      (ren_n),
      .oe_n       (oe_n),
      .rt_n       (rt_n),
      .out_narrow (out_narrow),
      .big_end    (big_end),
      .wgray_x    (wgray),
      .rdata      (rdata),
      .empty      (empty),
      .raddr      (raddr),
      .rgray      (rgray),
      .rptr       (rptr),
      .rd_q       (rd_q)
   );

   assign dout = oe_n ? {DW{1'bz}} : rd_q;
endmodule

// File: rtl/lbf_fifo_chk.sv
module lbf_fifo_chk #(
   parameter int DW = 18,
   parameter int PW = 11
) (
   input logic          wclk,
   input logic          wrst_n,
   input logic          rclk,
   input logic          rrst_n,
   input logic          wen_n,
   input logic          ren_n,
   input logic          oe_n,
   input logic          rt_n,
   input logic          in_narrow,
   input logic          full,
   input logic          empty,
   input logic [PW-1:0] wptr,
   input logic [PW-1:0] rptr,
   input logic [DW-1:0] rd_q
);
   assert_no_overflow_R3: assert property (@(posedge wclk) disable iff (!wrst_n)
      (full && !wen_n) |=> $stable(wptr));

   assert_wide_step_R2: assert property (@(posedge wclk) disable iff (!wrst_n)
      (!wen_n && !full && !in_narrow) |=> (wptr == $past(wptr) + PW'(1)));

   assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rrst_n)
      (empty && !ren_n && rt_n) |=> $stable(rptr));

   assert_skip_hold_R8: assert property (@(posedge rclk) disable iff (!rrst_n)
      oe_n |=> $stable(rd_q));

   assert_rewind_R9: assert property (@(posedge rclk) disable iff (!rrst_n)
      !rt_n |=> (rptr == '0));
endmodule

bind lbf_fifo lbf_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
   .wclk      (wclk),
   .wrst_n    (wrst_n),
   .rclk      (rclk),
   .rrst_n    (rrst_n),
   .wen_n     (wen_n),
   .ren_n     (ren_n),
   .oe_n      (oe_n),
   .rt_n      (rt_n),
   .in_narrow (in_narrow),
   .full      (full),
   .empty     (empty),
   .wptr      (wptr),
   .rptr      (rptr),
   .rd_q      (rd_q)
);

// File: tb/tb_lbf_fifo.sv
module tb_lbf_fifo;
   localparam int DW = 18;
   localparam int HW = 9;
   localparam int D  = 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, wen_n, ren_n, oe_n, rt_n;
   logic          in_narrow, out_narrow, big_end;
   logic [DW-1:0] din;
   logic          full, empty;
   wire  [DW-1:0] dout;

   lbf_fifo #(.DW(DW), .DEPTH(D), .SYNC_STAGES(2)) dut (
      .wclk       (clk),
      .wrst_n     (rst_n),
      .wen_n      (wen_n),
      .din        (din),
      .in_narrow  (in_narrow),
      .full       (full),
      .rclk       (clk),
      .rrst_n     (rst_n),
      .ren_n      (ren_n),
      .oe_n       (oe_n),
      .rt_n       (rt_n),
      .out_narrow (out_narrow),
      .big_end    (big_end),
      .empty      (empty),
      .dout       (dout)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 0;
   string cur_req = "R1";

   // Behavioural reference: queue contents and pointer counts, with the
   // crossing modelled as a two-edge delay of each side's count.
   logic [DW-1:0] mmem [D];
   int            mW, mR, wsA, wsB, rsA, rsB;
   bit            wslot, rslot, full_pre, empty_pre;
   logic [HW-1:0] hold, lo, hi;
   logic [DW-1:0] mq, word, ov;
   bit            e_exp, f_exp;

   always @(posedge clk) begin
      if (!rst_n) begin
         mW = 0; mR = 0; wsA = 0; wsB = 0; rsA = 0; rsB = 0;
         wslot = 0; rslot = 0; hold = '0; mq = '0;
         e_exp = 1; f_exp = 0;
      end else begin
         full_pre  = (mW - rsB) == D;
         empty_pre = (mR == wsB);
         wsB = wsA; wsA = mW;
         rsB = rsA; rsA = mR;
         if (!rt_n) begin
            mR = 0; rslot = 0;
         end else if (!ren_n && !empty_pre) begin
            word = mmem[mR % D];
            lo = word[HW-1:0];
            hi = word[DW-1:HW];
            if (out_narrow) ov = {9'd0, (rslot ^ big_end) ? hi : lo};
            else            ov = big_end ? {lo, hi} : word;
            if (!oe_n) mq = ov;
            if (!out_narrow || rslot) mR++;
            if (out_narrow) rslot = !rslot;
         end
         if (!wen_n && !full_pre) begin
            if (in_narrow) begin
               if (!wslot) begin
                  hold = din[HW-1:0]; wslot = 1;
               end else begin
                  mmem[mW % D] = big_end ? {hold, din[HW-1:0]} : {din[HW-1:0], hold};
                  mW++; wslot = 0;
               end
            end else begin
               mmem[mW % D] = din; mW++;
            end
         end
         e_exp = (mR == wsB);
         f_exp = (mW - rsB) == D;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "empty", DW'(empty), DW'(e_exp));
         check(cur_req, "full",  DW'(full),  DW'(f_exp));
         if (!oe_n) check(cur_req, "dout", dout, mq);
      end
   end

   task automatic drive(input logic w, input logic [DW-1:0] d, input logic r,
                        input logic o, input logic t);
      @(posedge clk); #1;
      wen_n = w; din = d; ren_n = r; oe_n = o; rt_n = t;
   endtask

   task automatic idle(input int n);
      repeat (n) drive(1'b1, '0, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic do_reset(input logic inn, input logic outn, input logic be);
      @(posedge clk); #1;
      rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; oe_n = 1'b0; rt_n = 1'b1;
      in_narrow = inn; out_narrow = outn; big_end = be;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   function automatic logic [DW-1:0] pat(input int i);
      return {9'(i * 3 + 1), 9'(i * 5 + 100)};
   endfunction

   task automatic write_n(input int n, input int base);
      for (int i = 0; i < n; i++) drive(1'b0, pat(base + i), 1'b1, 1'b0, 1'b1);
      idle(1);
   endtask

   task automatic read_n(input int n, input logic o);
      for (int i = 0; i < n; i++) drive(1'b1, '0, 1'b0, o, 1'b1);
      idle(1);
   endtask

   initial begin
      rst_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; oe_n = 1'b0; rt_n = 1'b1;
      in_narrow = 1'b0; out_narrow = 1'b0; big_end = 1'b0; din = '0;
      do_reset(1'b0, 1'b0, 1'b0);
      cur_req = "R1";
      idle(3);

      cur_req = "R2";
      write_n(5, 0); idle(3); read_n(5, 1'b0);
      for (int i = 0; i < 24; i++) drive(1'b0, pat(40 + i), 1'b0, 1'b0, 1'b1);
      idle(4); read_n(6, 1'b0);

      cur_req = "R4";
      read_n(4, 1'b0);
      drive(1'b0, pat(90), 1'b0, 1'b0, 1'b1);
      read_n(6, 1'b0);

      cur_req = "R3";
      write_n(D + 3, 100); idle(4);
      cur_req = "R11";
      read_n(3, 1'b0); write_n(5, 200); idle(3); read_n(D + 2, 1'b0);

      cur_req = "R7";
      do_reset(1'b0, 1'b0, 1'b1);
      write_n(4, 300); idle(3); read_n(5, 1'b0);

      cur_req = "R5";
      do_reset(1'b1, 1'b0, 1'b0);
      write_n(8, 400); idle(3); read_n(5, 1'b0);
      do_reset(1'b1, 1'b0, 1'b1);
      write_n(8, 420); idle(3); read_n(5, 1'b0);

      cur_req = "R6";
      do_reset(1'b0, 1'b1, 1'b0);
      write_n(3, 500); idle(3); read_n(7, 1'b0);
      do_reset(1'b0, 1'b1, 1'b1);
      write_n(3, 520); idle(3); read_n(7, 1'b0);
      do_reset(1'b1, 1'b1, 1'b1);
      write_n(6, 540); idle(3); read_n(7, 1'b0);

      cur_req = "R8";
      do_reset(1'b0, 1'b0, 1'b0);
      write_n(8, 600); idle(3);
      for (int i = 0; i < 8; i++) drive(1'b1, '0, 1'b0, 1'(i % 3 == 1), 1'b1);
      idle(2);

      cur_req = "R9";
      do_reset(1'b0, 1'b0, 1'b0);
      write_n(6, 700); idle(3); read_n(6, 1'b0);
      drive(1'b1, '0, 1'b0, 1'b0, 1'b0);
      idle(3); read_n(7, 1'b0);
      drive(1'b1, '0, 1'b1, 1'b0, 1'b0);
      idle(3); read_n(2, 1'b0);

      cur_req = "R10";
      do_reset(1'b1, 1'b0, 1'b0);
      drive(1'b0, 18'h000AB, 1'b1, 1'b0, 1'b1);
      idle(1);
      do_reset(1'b1, 1'b0, 1'b0);
      idle(3);
      write_n(4, 800); idle(3); read_n(3, 1'b0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule